// File: doc/BRIEF.md
# SPI DMA Transfer Engine

This block runs a full-duplex SPI transfer of a programmed number of bytes with no processor help per byte. For each byte it reads the outgoing byte from a byte-wide memory with 16-bit addresses and hands it to an SPI master byte shifter. When the shifter reports that the exchange is finished, the engine writes the byte that came back into the same memory. The read pointer and the write pointer each step by one after every byte. A readable counter shows how many bytes have been completed.

Software programs a length, a read base and a write base, and can optionally hand one of four active-low chip-select lines to the engine. It then sets a start bit and waits for a sticky completion flag. In automatic mode the engine holds the chosen line low for the whole transfer and then gives it back to the level software drives on it. The length field is encoded as count minus one, so an 8-bit field covers 1 to 256 bytes.

Top module: `spidma_engine`

## Requirements
- R1: A length value N written at register offset 1 makes the engine move exactly N+1 bytes: N=0 moves one byte and N=255 moves 256 bytes.
- R2: The read-only progress register at offset 2 reads 0 right after a start write. It gains one after each byte's memory write and reads (N+1) mod 256 once the transfer is over.
- R3: Byte k is fetched from the read base plus k. The read base is written as a high byte at offset 3 and a low byte at offset 4. Read data is taken in the cycle after `mem_rd_en`.
- R4: The byte the shifter returns for byte k is written to the write base plus k. The write base is written as a high byte at offset 5 and a low byte at offset 6.
- R5: Each byte follows the same order: memory read, then `spi_start` carrying the fetched byte, issued only while `spi_busy` is low, then a wait for `spi_done`, then a memory write of `spi_rx`. Each write completes before the next read is issued.
- R6: With the auto-select bit (offset 7, bit 2) at 0, `cs_n` equals `cs_sw` at all times.
- R7: With the auto-select bit at 1, the selected line is held low for as long as the engine is busy. The other lines follow `cs_sw` throughout. When busy drops, the selected line returns to its `cs_sw` level.
- R8: The select field (offset 7, bits 1:0) picks the controlled line: 00 picks line 0, 01 line 1, 10 line 2 and 11 line 3.
- R9: The control register is at offset 0. Writing 1 to bit 0 starts a transfer. Bit 2 reads busy. Bit 1 reads the done flag, which is also driven on `xfer_done`. The flag rises on the clock edge where the final write happens and busy clears, stays set after that, and is cleared by writing 1 to bit 1.
- R10: While the engine is busy, writes to offsets 1 and 3 to 7 and start requests have no effect.
- R11: After reset, all configuration registers, progress, busy and done read 0. No memory or shifter strobe is active, and `cs_n` equals `cs_sw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address for either strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd_en` |
| spi_start | output | 1 | One-cycle request to exchange one byte |
| spi_tx | output | 8 | Byte to send, valid with `spi_start` |
| spi_busy | input | 1 | Shifter is exchanging a byte |
| spi_done | input | 1 | One-cycle pulse: exchange finished, `spi_rx` valid |
| spi_rx | input | 8 | Byte received by the shifter |
| cs_sw | input | 4 | Software-driven chip-select levels |
| cs_n | output | 4 | Chip-select lines after automatic override |
| xfer_done | output | 1 | Sticky transfer-complete flag |

## Verification
A start write takes effect at the next clock edge, and the first memory read is issued in the cycle after that. The bench therefore reads progress one full cycle after the start write, well before the first byte can finish. Each byte needs a read cycle, a load cycle and a send cycle, then the shifter latency, then one store cycle. For that reason the bench never predicts an absolute cycle for a byte. A monitor checks every strobe at the clock edge where it is registered, and results are read at the falling edge after `xfer_done` rises. Because done and not-busy change on the same edge as the final write, the memory contents, the progress count and the restored `cs_n` are all valid at that falling edge. Chip-select levels during the transfer are captured at each `spi_start`.

// File: rtl/spidma_pkg.sv
`timescale 1ns/1ps
package spidma_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int LEN_W    = 8;
    localparam int CS_LINES = 4;
    localparam int SEL_W    = $clog2(CS_LINES);
    localparam int RA_W     = 4;

    // register offsets
    localparam logic [RA_W-1:0] RA_CTRL   = 4'd0;
    localparam logic [RA_W-1:0] RA_LEN    = 4'd1;
    localparam logic [RA_W-1:0] RA_PROG   = 4'd2;
    localparam logic [RA_W-1:0] RA_SRC_HI = 4'd3;
    localparam logic [RA_W-1:0] RA_SRC_LO = 4'd4;
    localparam logic [RA_W-1:0] RA_DST_HI = 4'd5;
    localparam logic [RA_W-1:0] RA_DST_LO = 4'd6;
    localparam logic [RA_W-1:0] RA_CSCFG  = 4'd7;

    // bit positions
    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_DONE_BIT  = 1;
    localparam int CTRL_BUSY_BIT  = 2;
    localparam int CSCFG_AUTO_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_SEND  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_STORE = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              auto_cs;
        logic [SEL_W-1:0]  sel;
    } cfg_t;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] src_ptr;
        logic [ADDR_W-1:0] dst_ptr;
        logic [LEN_W-1:0]  cnt;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              done;
    } seq_t;

endpackage

// File: rtl/spidma_regs.sv
`timescale 1ns/1ps
module spidma_regs
    import spidma_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_RA_W   = RA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [P_RA_W-1:0]   addr,
    input  logic [P_DATA_W-1:0] wdata,
    output logic [P_DATA_W-1:0] rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [LEN_W-1:0]    progress,
    output cfg_t                cfg,
    output logic                start_pulse,
    output logic                done_clr
);

    localparam int HI_LSB = P_ADDR_W - P_DATA_W;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && !busy) begin
            case (addr)
                RA_LEN:    cfg_d.len = wdata[LEN_W-1:0];
                RA_SRC_HI: cfg_d.src[P_ADDR_W-1:HI_LSB] = wdata;
                RA_SRC_LO: cfg_d.src[P_DATA_W-1:0] = wdata;
                RA_DST_HI: cfg_d.dst[P_ADDR_W-1:HI_LSB] = wdata;
                RA_DST_LO: cfg_d.dst[P_DATA_W-1:0] = wdata;
                RA_CSCFG: begin
                    cfg_d.sel     = wdata[SEL_W-1:0];
                    cfg_d.auto_cs = wdata[CSCFG_AUTO_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg         = cfg_q;
    assign start_pulse = we && (addr == RA_CTRL) && wdata[CTRL_START_BIT] && !busy;
    assign done_clr    = we && (addr == RA_CTRL) && wdata[CTRL_DONE_BIT];

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL: begin
                rdata[CTRL_DONE_BIT] = done;
                rdata[CTRL_BUSY_BIT] = busy;
            end
            RA_LEN:    rdata[LEN_W-1:0] = cfg_q.len;
            RA_PROG:   rdata[LEN_W-1:0] = progress;
            RA_SRC_HI: rdata = cfg_q.src[P_ADDR_W-1:HI_LSB];
            RA_SRC_LO: rdata = cfg_q.src[P_DATA_W-1:0];
            RA_DST_HI: rdata = cfg_q.dst[P_ADDR_W-1:HI_LSB];
            RA_DST_LO: rdata = cfg_q.dst[P_DATA_W-1:0];
            RA_CSCFG: begin
                rdata[SEL_W-1:0]      = cfg_q.sel;
                rdata[CSCFG_AUTO_BIT] = cfg_q.auto_cs;
            end
            default: rdata = '0;
        endcase
    end

    // R10: configuration stays put for the whole transfer
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/spidma_seq.sv
`timescale 1ns/1ps
module spidma_seq
    import spidma_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_LEN_W  = LEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                done_clr,
    input  logic [P_LEN_W-1:0]  len,
    input  logic [P_ADDR_W-1:0] src_base,
    input  logic [P_ADDR_W-1:0] dst_base,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [P_ADDR_W-1:0] mem_addr,
    output logic [P_DATA_W-1:0] mem_wdata,
    input  logic [P_DATA_W-1:0] mem_rdata,
    output logic                spi_start,
    output logic [P_DATA_W-1:0] spi_tx,
    input  logic                spi_busy,
    input  logic                spi_done,
    input  logic [P_DATA_W-1:0] spi_rx,
    output logic                busy,
    output logic                done,
    output logic [P_LEN_W-1:0]  progress
);

    seq_t s_d, s_q;
    logic last_byte;

    assign last_byte = (s_q.cnt == len);

    always_comb begin
        s_d       = s_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        spi_start = 1'b0;
        if (done_clr) s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state   = ST_FETCH;
                    s_d.src_ptr = src_base;
                    s_d.dst_ptr = dst_base;
                    s_d.cnt     = '0;
                end
            end
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                s_d.state = ST_LOAD;
            end
            ST_LOAD: begin
                s_d.tx    = mem_rdata;
                s_d.state = ST_SEND;
            end
            ST_SEND: begin
                if (!spi_busy) begin
                    spi_start = 1'b1;
                    s_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (spi_done) begin
                    s_d.rx    = spi_rx;
                    s_d.state = ST_STORE;
                end
            end
            ST_STORE: begin
                mem_wr_en   = 1'b1;
                s_d.cnt     = s_q.cnt + 1'b1;
                s_d.src_ptr = s_q.src_ptr + 1'b1;
                s_d.dst_ptr = s_q.dst_ptr + 1'b1;
                if (last_byte) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.state = ST_FETCH;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_addr  = (s_q.state == ST_STORE) ? s_q.dst_ptr : s_q.src_ptr;
    assign mem_wdata = s_q.rx;
    assign spi_tx    = s_q.tx;
    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign progress  = s_q.cnt;

    // R5: a write always follows a finished exchange
    a_r5_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(spi_done));

    // R5: a read follows either the previous write or the idle start
    a_r5_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ($past(mem_wr_en) || !$past(busy)));

    // R2: progress moves by at most one per cycle during a transfer
    a_r2_progress_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((s_q.cnt == $past(s_q.cnt)) || (s_q.cnt == $past(s_q.cnt) + 1'b1)));

    // R1: the transfer ends with N+1 bytes counted
    a_r1_final_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (s_q.cnt == P_LEN_W'(len + 1'b1)));

    // R9: done rises only together with leaving busy
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

endmodule

// File: rtl/spidma_csel.sv
`timescale 1ns/1ps
module spidma_csel
    import spidma_pkg::*;
#(
    parameter int P_LINES = CS_LINES,
    parameter int P_SEL_W = SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               auto_en,
    input  logic [P_SEL_W-1:0] sel,
    input  logic [P_LINES-1:0] cs_sw,
    output logic [P_LINES-1:0] cs_n
);

    logic take_over;
    assign take_over = busy && auto_en;

    for (genvar i = 0; i < P_LINES; i++) begin : g_line
        assign cs_n[i] = (take_over && (sel == P_SEL_W'(i))) ? 1'b0 : cs_sw[i];
    end

    // R6: no takeover means software levels pass straight through
    a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !take_over |-> (cs_n == cs_sw));

    // R7: at most one line differs from software during a takeover
    a_r7_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        take_over |-> ($onehot0(cs_n ^ cs_sw) && ($countones(cs_n) <= $countones(cs_sw))));

endmodule

// File: rtl/spidma_engine.sv
`timescale 1ns/1ps
module spidma_engine
    import spidma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              spi_start,
    output logic [DATA_W-1:0] spi_tx,
    input  logic              spi_busy,
    input  logic              spi_done,
    input  logic [DATA_W-1:0] spi_rx,
    input  logic [CS_LINES-1:0] cs_sw,
    output logic [CS_LINES-1:0] cs_n,
    output logic              xfer_done
);

    cfg_t             cfg;
    logic             start_pulse;
    logic             done_clr;
    logic             busy;
    logic             done;
    logic [LEN_W-1:0] progress;

    spidma_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .busy        (busy),
        .done        (done),
        .progress    (progress),
        .cfg         (cfg),
        .start_pulse (start_pulse),
        .done_clr    (done_clr)
    );

    spidma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_pulse),
        .done_clr  (done_clr),
        .len       (cfg.len),
        .src_base  (cfg.src),
        .dst_base  (cfg.dst),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .spi_start (spi_start),
        .spi_tx    (spi_tx),
        .spi_busy  (spi_busy),
        .spi_done  (spi_done),
        .spi_rx    (spi_rx),
        .busy      (busy),
        .done      (done),
        .progress  (progress)
    );

    spidma_csel u_csel (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .auto_en (cfg.auto_cs),
        .sel     (cfg.sel),
        .cs_sw   (cs_sw),
        .cs_n    (cs_n)
    );

    assign xfer_done = done;

    // R11: no strobes while idle
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en && !spi_start));

endmodule

// File: tb/spidma_engine_tb.sv
`timescale 1ns/1ps
module spidma_engine_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        spi_start;
    logic [7:0]  spi_tx;
    logic        spi_busy, spi_done;
    logic [7:0]  spi_rx;
    logic [3:0]  cs_sw, cs_n;
    logic        xfer_done;

    spidma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .spi_start(spi_start), .spi_tx(spi_tx),
        .spi_busy(spi_busy), .spi_done(spi_done), .spi_rx(spi_rx),
        .cs_sw(cs_sw), .cs_n(cs_n), .xfer_done(xfer_done)
    );

    int total = 0;
    int bad   = 0;

    // memory model: 4 KiB window, registered read data
    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'((i * 7 + 3) ^ (i >> 8));
            mem_rdata <= '0;
        end else begin
            if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
            if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    // shifter model
    int         lat;
    logic [7:0] key;
    logic       hold_busy;
    logic       sh_busy;
    int         sh_cnt;
    logic [7:0] sh_tx;
    assign spi_busy = sh_busy | hold_busy;
    always @(posedge clk) begin
        if (!rst_n) begin
            sh_busy <= 1'b0; sh_cnt <= 0; sh_tx <= '0; spi_done <= 1'b0; spi_rx <= '0;
        end else begin
            spi_done <= 1'b0;
            if (spi_start) begin
                sh_busy <= 1'b1; sh_cnt <= lat; sh_tx <= spi_tx;
            end else if (sh_busy) begin
                if (sh_cnt == 0) begin
                    sh_busy <= 1'b0; spi_done <= 1'b1; spi_rx <= sh_tx ^ key;
                end else begin
                    sh_cnt <= sh_cnt - 1;
                end
            end
        end
    end

    // monitor
    logic        mon_clr;
    logic [15:0] exp_src, exp_dst;
    int rd_cnt, wr_cnt, st_cnt, ord_err, src_err, dst_err, tx_err;
    logic [3:0] cs_snap;
    always @(posedge clk) begin
        if (mon_clr) begin
            rd_cnt <= 0; wr_cnt <= 0; st_cnt <= 0; ord_err <= 0;
            src_err <= 0; dst_err <= 0; tx_err <= 0; cs_snap <= '0;
        end else begin
            if (mem_rd_en) begin
                if (rd_cnt != wr_cnt) ord_err <= ord_err + 1;
                if (mem_addr != exp_src + 16'(rd_cnt)) src_err <= src_err + 1;
                rd_cnt <= rd_cnt + 1;
            end
            if (mem_wr_en) begin
                if (mem_addr != exp_dst + 16'(wr_cnt)) dst_err <= dst_err + 1;
                wr_cnt <= wr_cnt + 1;
            end
            if (spi_start) begin
                if (spi_busy) ord_err <= ord_err + 1;
                if (spi_tx != mem[12'(exp_src + 16'(st_cnt))]) tx_err <= tx_err + 1;
                st_cnt  <= st_cnt + 1;
                cs_snap <= cs_n;
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog: act=%0d exp<=190000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(input int n, input logic [15:0] s, input logic [15:0] d,
                         input logic [7:0] cfg, input logic [7:0] k, input int l);
        wr(4'd0, 8'h02);
        wr(4'd1, 8'(n));
        wr(4'd3, s[15:8]); wr(4'd4, s[7:0]);
        wr(4'd5, d[15:8]); wr(4'd6, d[7:0]);
        wr(4'd7, cfg);
        key = k; lat = l; exp_src = s; exp_dst = d;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int guard = 0;
        while (!xfer_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(xfer_done, {tag, " done timeout"}, int'(xfer_done), 1);
    endtask

    function automatic int mismatches(input int n, input logic [15:0] s,
                                      input logic [15:0] d, input logic [7:0] k);
        int m = 0;
        for (int i = 0; i <= n; i++)
            if (mem[12'(d + 16'(i))] != (mem[12'(s + 16'(i))] ^ k)) m++;
        return m;
    endfunction

    task automatic verify(input int n, input logic [15:0] s, input logic [15:0] d);
        logic [7:0] v;
        check(wr_cnt == n + 1, "R1 byte count", wr_cnt, n + 1);
        check(ord_err == 0, "R5 ordering", ord_err, 0);
        check(tx_err == 0, "R5 tx byte", tx_err, 0);
        check(src_err == 0, "R3 read address", src_err, 0);
        check(dst_err == 0, "R4 write address", dst_err, 0);
        check(mismatches(n, s, d, key) == 0, "R4 data", mismatches(n, s, d, key), 0);
        rd(4'd2, v);
        check(v == 8'(n + 1), "R2 final progress", v, 8'(n + 1));
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), v);
            check(v == 8'h00, "R11 reset register", v, 0);
        end
        check(!xfer_done, "R11 reset done", xfer_done, 0);
        check(!mem_rd_en && !mem_wr_en && !spi_start, "R11 reset strobes",
              {mem_rd_en, mem_wr_en, spi_start}, 0);
        check(cs_n == cs_sw, "R11 reset cs", cs_n, cs_sw);
    endtask

    task automatic t_single();
        cs_sw = 4'b1111;
        setup(0, 16'h0100, 16'h0800, 8'h02, 8'h5A, 2);
        wr(4'd0, 8'h01);
        wait_done("R1 single");
        verify(0, 16'h0100, 16'h0800);
        check(cs_snap == cs_sw, "R6 cs untouched", cs_snap, cs_sw);
    endtask

    task automatic t_auto_sel();
        for (int s = 0; s < 4; s++) begin
            logic [3:0] exp;
            cs_sw = 4'b1111 ^ 4'(1 << ((s + 1) % 4));
            exp   = cs_sw & ~4'(1 << s);
            setup(2, 16'h0200 + 16'(s * 16), 16'h0900 + 16'(s * 16),
                  8'h04 | 8'(s), 8'h33 + 8'(s), 1 + s);
            wr(4'd0, 8'h01);
            wait_done("R7 auto");
            verify(2, 16'h0200 + 16'(s * 16), 16'h0900 + 16'(s * 16));
            check(cs_snap == exp, "R8 selected line low", cs_snap, exp);
            check(cs_n == cs_sw, "R7 line restored", cs_n, cs_sw);
        end
    endtask

    task automatic t_full();
        cs_sw = 4'b1011;
        setup(255, 16'h0300, 16'h0A00, 8'h01, 8'hC3, 1);
        wr(4'd0, 8'h01);
        wait_done("R1 full");
        verify(255, 16'h0300, 16'h0A00);
        check(cs_snap == cs_sw, "R6 auto off passthrough", cs_snap, cs_sw);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        setup(4, 16'h0500, 16'h0C00, 8'h00, 8'h11, 2);
        wr(4'd0, 8'h01);
        wait_done("R2 first");
        rd(4'd2, v);
        check(v == 8'd5, "R2 progress after 5", v, 5);
        setup(9, 16'h0540, 16'h0C40, 8'h00, 8'h22, 2);
        wr(4'd0, 8'h01);
        rd(4'd2, v);
        check(v == 8'd0, "R2 cleared by start", v, 0);
        wait_done("R2 second");
        verify(9, 16'h0540, 16'h0C40);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        setup(7, 16'h0600, 16'h0D00, 8'h01, 8'h77, 6);
        wr(4'd0, 8'h01);
        wr(4'd1, 8'h02);
        wr(4'd4, 8'h55);
        wr(4'd6, 8'h66);
        wr(4'd7, 8'h07);
        wr(4'd0, 8'h01);
        wait_done("R10");
        verify(7, 16'h0600, 16'h0D00);
        rd(4'd1, v); check(v == 8'd7, "R10 length kept", v, 7);
        rd(4'd4, v); check(v == 8'h00, "R10 read base kept", v, 0);
        rd(4'd6, v); check(v == 8'h00, "R10 write base kept", v, 0);
        rd(4'd7, v); check(v == 8'h01, "R10 select cfg kept", v, 1);
    endtask

    task automatic t_done();
        logic [7:0] v;
        setup(3, 16'h0700, 16'h0E00, 8'h00, 8'h0F, 3);
        wr(4'd0, 8'h01);
        rd(4'd0, v);
        check(v == 8'h04, "R9 busy bit set, done clear", v, 4);
        wait_done("R9");
        rd(4'd0, v);
        check(v == 8'h02, "R9 done set, busy clear", v, 2);
        repeat (5) @(negedge clk);
        check(xfer_done, "R9 done sticky", xfer_done, 1);
        wr(4'd0, 8'h02);
        rd(4'd0, v);
        check(v == 8'h00 && !xfer_done, "R9 write-one clears done", v, 0);
    endtask

    task automatic t_shifter_busy();
        logic [7:0] v;
        hold_busy = 1'b1;
        setup(1, 16'h0780, 16'h0F00, 8'h00, 8'h99, 2);
        wr(4'd0, 8'h01);
        repeat (20) @(negedge clk);
        check(st_cnt == 0, "R5 start held while shifter busy", st_cnt, 0);
        rd(4'd0, v);
        check(v[2] == 1'b1, "R5 still busy", v, 4);
        hold_busy = 1'b0;
        wait_done("R5");
        verify(1, 16'h0780, 16'h0F00);
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        cs_sw = 4'b1111; lat = 2; key = '0; hold_busy = 1'b0;
        mon_clr = 1'b1; exp_src = '0; exp_dst = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        t_reset();
        t_single();
        t_auto_sel();
        t_full();
        t_restart();
        t_busy_ignore();
        t_done();
        t_shifter_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule